// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

A small single-port memory of one-bit cells that can be given one known defect at a time. It is meant for checking memory test controllers, such as a March-style test sequencer: the controller drives the ordinary read and write pins, and a separate configuration bus plants one defect into the array. The test then shows whether the controller's algorithm detects that defect.

Five defect families can be injected. In a stuck cell, the read value is fixed. A transition defect stops a cell from changing in one direction. An inverting coupling defect flips a victim cell when an aggressor cell changes in one direction. A forcing coupling defect drives the victim to a chosen value instead. A pattern-sensitive defect sets a victim that holds 0 to 1 when all of its neighbours hold 1, where the neighbours are either the four orthogonal cells or all eight surrounding cells.

The cells form a grid. The low address bits select the column and the high bits select the row. Neighbours that would fall outside the grid are skipped. With the default parameters the grid is 4x4, so address bits [1:0] give the column and bits [3:2] give the row.

Top module: `fault_inject_ram`

## Requirements
- R1: While rstN is low, every cell is cleared to 0, rdData is cleared to 0 and the injected defect is cleared to none.
- R2: In a clock cycle with wrEn low, rdData takes the value held at addr on the next rising edge, so it is valid one clock after the address. In a cycle with wrEn high, rdData keeps its previous value.
- R3: cfgType code 0 and all unused codes (7 to 15) select fault-free operation. In that mode every write stores wrData at addr.
- R4: Code 1 (stuck cell): a read of the victim always returns cfgPolarity[0], whatever is written to the victim.
- R5: Code 2 (transition): with cfgPolarity[0]=1, a write of 1 over a stored 0 in the victim is lost. With cfgPolarity[0]=0, a write of 0 over a stored 1 in the victim is lost. All other writes store normally.
- R6: Code 3 (inverting coupling): when a write changes the aggressor in the selected direction, the victim is complemented at the same edge. cfgPolarity[0]=1 selects 0-to-1 and cfgPolarity[0]=0 selects 1-to-0.
- R7: Code 4 (forcing coupling): the direction is selected by cfgPolarity[0] as in R6. The victim is set to cfgPolarity[1] at the same edge.
- R8: A coupling defect acts only on a write that changes the aggressor's stored value. A write of the value already held has no effect on the victim. A configuration whose victim equals its aggressor has no coupling effect.
- R9: Code 5 (orthogonal pattern): after any write, if the victim holds 0 and every in-grid north, south, east and west neighbour holds 1, the victim holds 1 from that same edge.
- R10: Code 6 (full pattern): the same rule as R9, but over all in-grid cells among the eight surrounding the victim, diagonals included.
- R11: The defect settings are loaded from the configuration inputs on a rising edge where cfgStrobe is high and wrEn is low. A strobe that arrives together with a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 4 | Cell address; row in the upper bits, column in the lower bits |
| wrEn | input | 1 | Write enable |
| wrData | input | 1 | Bit to write |
| cfgStrobe | input | 1 | Loads the defect settings when no write is in progress |
| cfgType | input | 4 | Defect code (0 none, 1 stuck, 2 transition, 3 inverting coupling, 4 forcing coupling, 5 orthogonal pattern, 6 full pattern) |
| cfgVictim | input | 4 | Address of the victim cell |
| cfgAggressor | input | 4 | Address of the aggressor cell, used by codes 3 and 4 |
| cfgPolarity | input | 2 | Bit 0: stuck value, blocked direction or trigger direction; bit 1: value forced by code 4 |
| rdData | output | 1 | Registered read data |

## Verification
The hardest state to reach from the ports is the pattern-sensitive trigger. It needs every in-grid neighbour of the victim at 1 while the victim itself is still 0. Random addresses and data almost never produce that. The random phases therefore point most accesses at the victim, the aggressor and cells at neighbour offsets, and they write mostly ones while a pattern defect is active. Directed sequences add a corner victim with only two orthogonal neighbours, and a centre victim whose one zero lies on a diagonal, which separates R9 from R10.

// File: rtl/fim_pkg.sv
`timescale 1ns/1ps
package fim_pkg;

  localparam int CFG_CODE_W = 4;

  typedef enum logic [2:0] {
    FAULT_NONE      = 3'd0,
    FAULT_STUCK     = 3'd1,
    FAULT_TRANS     = 3'd2,
    FAULT_CPL_INV   = 3'd3,
    FAULT_CPL_FORCE = 3'd4,
    FAULT_PAT_ORTH  = 3'd5,
    FAULT_PAT_FULL  = 3'd6
  } faultKind_e;

  // Strobes from the control to the cell array, valid for one cycle
  typedef struct packed {
    logic cellWrite;     // store wrData at addr
    logic victimInvert;  // complement the victim
    logic victimForce;   // drive the victim to forceValue
    logic forceValue;
    logic patternCheck;  // evaluate the neighbour pattern after this write
    logic patternWide;   // eight neighbours instead of four
    logic stuckRead;     // replace the read value
    logic stuckValue;
    logic readLoad;      // capture read data this cycle
  } cellStrobe_t;

endpackage

// File: rtl/fim_ctrl.sv
`timescale 1ns/1ps
module fim_ctrl
  import fim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  wrData,
  input  logic                  cfgStrobe,
  input  logic [CFG_CODE_W-1:0] cfgType,
  input  logic [ADDR_W-1:0]     cfgVictim,
  input  logic [ADDR_W-1:0]     cfgAggressor,
  input  logic [1:0]            cfgPolarity,
  input  logic                  curBit,
  output cellStrobe_t           strobe,
  output faultKind_e            faultKind,
  output logic [ADDR_W-1:0]     victimAddr,
  output logic [ADDR_W-1:0]     aggrAddr,
  output logic [1:0]            faultPol
);

  faultKind_e kindIn;
  logic       cfgLoad;
  logic       hitVictim;
  logic       hitAggr;
  logic       transBlocked;
  logic       aggrChanges;
  logic       couplingFires;

  always_comb begin
    case (cfgType)
      4'd1:    kindIn = FAULT_STUCK;
      4'd2:    kindIn = FAULT_TRANS;
      4'd3:    kindIn = FAULT_CPL_INV;
      4'd4:    kindIn = FAULT_CPL_FORCE;
      4'd5:    kindIn = FAULT_PAT_ORTH;
      4'd6:    kindIn = FAULT_PAT_FULL;
      default: kindIn = FAULT_NONE;
    endcase
  end

  assign cfgLoad = cfgStrobe && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultKind  <= FAULT_NONE;
      victimAddr <= '0;
      aggrAddr   <= '0;
      faultPol   <= '0;
    end else if (cfgLoad) begin
      faultKind  <= kindIn;
      victimAddr <= cfgVictim;
      aggrAddr   <= cfgAggressor;
      faultPol   <= cfgPolarity;
    end
  end

  assign hitVictim = (addr == victimAddr);
  assign hitAggr   = (addr == aggrAddr);

  // Transition defect: pol[0]=1 blocks 0->1, pol[0]=0 blocks 1->0
  always_comb begin
    transBlocked = 1'b0;
    if (faultKind == FAULT_TRANS && hitVictim) begin
      if (faultPol[0]) transBlocked = !curBit && wrData;
      else             transBlocked = curBit && !wrData;
    end
  end

  assign aggrChanges   = wrEn && hitAggr && (curBit != wrData) && (victimAddr != aggrAddr);
  assign couplingFires = aggrChanges && (wrData == faultPol[0]);

  always_comb begin
    strobe              = '0;
    strobe.cellWrite    = wrEn && !transBlocked;
    strobe.victimInvert = couplingFires && (faultKind == FAULT_CPL_INV);
    strobe.victimForce  = couplingFires && (faultKind == FAULT_CPL_FORCE);
    strobe.forceValue   = faultPol[1];
    strobe.patternCheck = wrEn && (faultKind == FAULT_PAT_ORTH || faultKind == FAULT_PAT_FULL);
    strobe.patternWide  = (faultKind == FAULT_PAT_FULL);
    strobe.stuckRead    = (faultKind == FAULT_STUCK) && hitVictim;
    strobe.stuckValue   = faultPol[0];
    strobe.readLoad     = !wrEn;
  end

endmodule

// File: rtl/fim_datapath.sv
`timescale 1ns/1ps
module fim_datapath
  import fim_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrData,
  input  logic [ADDR_W-1:0] victimAddr,
  output logic              curBit,
  output logic              rdData,
  output logic [ROWS*COLS-1:0] cellState
);

  localparam int CELLS = ROWS * COLS;

  logic [CELLS-1:0] nextCells;
  logic [CELLS-1:0] nbrOrth;
  logic [CELLS-1:0] nbrFull;
  logic [CELLS-1:0] nbrMask;
  logic             patternHit;

  // Neighbour masks of the current victim, one decoder per cell
  for (genvar gi = 0; gi < CELLS; gi++) begin : g_nbr
    localparam int CELL_ROW = gi / COLS;
    localparam int CELL_COL = gi % COLS;
    always_comb begin
      int vRow;
      int vCol;
      int dRow;
      int dCol;
      vRow = int'(victimAddr) / COLS;
      vCol = int'(victimAddr) % COLS;
      dRow = (CELL_ROW > vRow) ? CELL_ROW - vRow : vRow - CELL_ROW;
      dCol = (CELL_COL > vCol) ? CELL_COL - vCol : vCol - CELL_COL;
      nbrOrth[gi] = (dRow + dCol == 1);
      nbrFull[gi] = (dRow <= 1) && (dCol <= 1) && (dRow + dCol != 0);
    end
  end

  assign nbrMask = strobe.patternWide ? nbrFull : nbrOrth;

  always_comb begin
    nextCells = cellState;
    if (strobe.cellWrite)    nextCells[addr]       = wrData;
    if (strobe.victimInvert) nextCells[victimAddr] = ~cellState[victimAddr];
    if (strobe.victimForce)  nextCells[victimAddr] = strobe.forceValue;
    patternHit = strobe.patternCheck && (&(nextCells | ~nbrMask)) && !nextCells[victimAddr];
    if (patternHit)          nextCells[victimAddr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cellState <= '0;
    else       cellState <= nextCells;
  end

  assign curBit = cellState[addr];

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= 1'b0;
    else if (strobe.readLoad) rdData <= strobe.stuckRead ? strobe.stuckValue : cellState[addr];
  end

endmodule

// File: rtl/fault_inject_ram.sv
`timescale 1ns/1ps
module fault_inject_ram
  import fim_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int CELLS  = ROWS * COLS,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  wrData,
  input  logic                  cfgStrobe,
  input  logic [CFG_CODE_W-1:0] cfgType,
  input  logic [ADDR_W-1:0]     cfgVictim,
  input  logic [ADDR_W-1:0]     cfgAggressor,
  input  logic [1:0]            cfgPolarity,
  output logic                  rdData
);

  cellStrobe_t       strobe;
  faultKind_e        faultKind;
  logic [ADDR_W-1:0] victimAddr;
  logic [ADDR_W-1:0] aggrAddr;
  logic [1:0]        faultPol;
  logic              curBit;
  logic [CELLS-1:0]  cellState;

  fim_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addr         (addr),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .cfgStrobe    (cfgStrobe),
    .cfgType      (cfgType),
    .cfgVictim    (cfgVictim),
    .cfgAggressor (cfgAggressor),
    .cfgPolarity  (cfgPolarity),
    .curBit       (curBit),
    .strobe       (strobe),
    .faultKind    (faultKind),
    .victimAddr   (victimAddr),
    .aggrAddr     (aggrAddr),
    .faultPol     (faultPol)
  );

  fim_datapath #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .wrData     (wrData),
    .victimAddr (victimAddr),
    .curBit     (curBit),
    .rdData     (rdData),
    .cellState  (cellState)
  );

endmodule

// File: rtl/fim_checker.sv
`timescale 1ns/1ps
module fim_checker
  import fim_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CELLS  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              wrData,
  input logic              cfgStrobe,
  input logic              rdData,
  input faultKind_e        faultKind,
  input logic [ADDR_W-1:0] victimAddr,
  input logic [ADDR_W-1:0] aggrAddr,
  input logic [1:0]        faultPol,
  input logic [CELLS-1:0]  cellState
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (rdData == 1'b0) && (cellState == '0) && (faultKind == FAULT_NONE));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(faultKind == FAULT_STUCK && addr == victimAddr))
      |=> rdData == $past(cellState[addr]));

  p_hold_on_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> $stable(rdData));

  p_ideal_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && faultKind == FAULT_NONE) |=> cellState[$past(addr)] == $past(wrData));

  p_stuck_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && faultKind == FAULT_STUCK && addr == victimAddr) |=> rdData == $past(faultPol[0]));

  p_up_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && faultKind == FAULT_TRANS && faultPol[0] && addr == victimAddr && !cellState[victimAddr])
      |=> !cellState[$past(victimAddr)]);

  p_same_value_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (faultKind == FAULT_CPL_INV || faultKind == FAULT_CPL_FORCE) && addr == aggrAddr
     && addr != victimAddr && wrData == cellState[addr]) |=> $stable(cellState));

  p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cfgStrobe) |=> $stable(faultKind) && $stable(victimAddr) && $stable(aggrAddr));

endmodule

bind fault_inject_ram fim_checker #(.ADDR_W(ADDR_W), .CELLS(CELLS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .cfgStrobe  (cfgStrobe),
  .rdData     (rdData),
  .faultKind  (faultKind),
  .victimAddr (victimAddr),
  .aggrAddr   (aggrAddr),
  .faultPol   (faultPol),
  .cellState  (cellState)
);

// File: tb/tb_fault_inject_ram.sv
`timescale 1ns/1ps
module tb_fault_inject_ram;

  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int CELLS  = ROWS * COLS;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              wrEn;
  logic              wrData;
  logic              cfgStrobe;
  logic [3:0]        cfgType;
  logic [ADDR_W-1:0] cfgVictim;
  logic [ADDR_W-1:0] cfgAggressor;
  logic [1:0]        cfgPolarity;
  logic              rdData;

  int  vecs = 0;
  int  bad  = 0;
  bit  finished = 1'b0;

  bit       model [CELLS];
  int       mKind;
  int       mVic;
  int       mAgg;
  bit [1:0] mPol;

  always #2.5 clk = ~clk;

  fault_inject_ram #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .cfgStrobe(cfgStrobe), .cfgType(cfgType), .cfgVictim(cfgVictim),
    .cfgAggressor(cfgAggressor), .cfgPolarity(cfgPolarity), .rdData(rdData)
  );

  function automatic int kindOf(int code);
    return (code >= 0 && code <= 6) ? code : 0;
  endfunction

  function automatic string tagOf(int kind);
    case (kind)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      6: return "R10";
      default: return "R3";
    endcase
  endfunction

  function automatic bit nbrAllOnes(int v, bit wide);
    for (int i = 0; i < CELLS; i++) begin
      int dr = (i / COLS) - (v / COLS);
      int dc = (i % COLS) - (v % COLS);
      int ar = dr < 0 ? -dr : dr;
      int ac = dc < 0 ? -dc : dc;
      bit isN = wide ? (ar <= 1 && ac <= 1 && (ar + ac) != 0) : (ar + ac == 1);
      if (isN && !model[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic void modelWrite(int a, bit d);
    bit old = model[a];
    bit blk = 1'b0;
    if (mKind == 2 && a == mVic) blk = mPol[0] ? (!old && d) : (old && !d);
    if (!blk) model[a] = d;
    if ((mKind == 3 || mKind == 4) && a == mAgg && mVic != mAgg && old != d && d == mPol[0])
      model[mVic] = (mKind == 3) ? !model[mVic] : mPol[1];
    if ((mKind == 5 || mKind == 6) && !model[mVic] && nbrAllOnes(mVic, mKind == 6))
      model[mVic] = 1'b1;
  endfunction

  function automatic bit expRead(int a);
    return (mKind == 1 && a == mVic) ? mPol[0] : model[a];
  endfunction

  task automatic check(string tag, int a, logic act, bit exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%0b expected=%0b", tag, a, act, exp);
    end
  endtask

  task automatic cfg(int code, int v, int ag, int pol);
    @(negedge clk);
    wrEn = 1'b0; cfgStrobe = 1'b1; cfgType = 4'(code);
    cfgVictim = ADDR_W'(v); cfgAggressor = ADDR_W'(ag); cfgPolarity = 2'(pol);
    @(negedge clk);
    cfgStrobe = 1'b0;
    mKind = kindOf(code); mVic = v; mAgg = ag; mPol = 2'(pol);
  endtask

  task automatic wr(int a, bit d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    wrEn = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
    check(tag == "" ? tagOf(mKind) : tag, a, rdData, expRead(a));
  endtask

  // Strobe raised together with a write: settings must not change (R11)
  task automatic wrWithCfg(int a, bit d, int code, int v, int pol);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    cfgStrobe = 1'b1; cfgType = 4'(code); cfgVictim = ADDR_W'(v);
    cfgAggressor = ADDR_W'(v); cfgPolarity = 2'(pol);
    @(negedge clk);
    wrEn = 1'b0; cfgStrobe = 1'b0;
    modelWrite(a, d);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit = $urandom(32'd20240611);
    int offs [8] = '{-5, -4, -3, -1, 1, 3, 4, 5};
    rstN = 1'b0; addr = '0; wrEn = 1'b0; wrData = 1'b0; cfgStrobe = 1'b0;
    cfgType = '0; cfgVictim = '0; cfgAggressor = '0; cfgPolarity = '0;
    for (int i = 0; i < CELLS; i++) model[i] = 1'b0;
    mKind = 0; mVic = 0; mAgg = 0; mPol = '0;
    if (seedInit == 0) seedInit = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", 0, rdData, 1'b0);
    for (int i = 0; i < CELLS; i++) rd(i, "R1");

    // R2 / R3: ideal writes, then an unused code
    for (int i = 0; i < CELLS; i++) wr(i, 1'((i * 5 + 1) % 3 == 0));
    for (int i = 0; i < CELLS; i++) rd(i, "R2");
    cfg(11, 3, 4, 3);
    wr(3, 1); wr(4, 0); wr(4, 1);
    rd(3, "R3"); rd(4, "R3");

    // R4: stuck at 1 on cell 6
    cfg(1, 6, 0, 1);
    rd(6, "R4"); wr(6, 0); rd(6, "R4"); rd(7, "R4");

    // R11: strobe during a write is ignored
    cfg(0, 0, 0, 0);
    wrWithCfg(3, 0, 1, 3, 1);
    rd(3, "R11");

    // R5: up blocked on 5, then down blocked on 8
    cfg(2, 5, 0, 1);
    wr(5, 0); wr(5, 1); rd(5, "R5");
    cfg(2, 8, 0, 0);
    wr(8, 1); wr(8, 0); rd(8, "R5");

    // R6 / R8: inverting on rise, aggressor 2 victim 9
    cfg(3, 9, 2, 1);
    wr(2, 0); wr(2, 1); rd(9, "R6");
    wr(2, 1); rd(9, "R8");
    wr(2, 0); rd(9, "R8");

    // R7: forcing 1 on fall, aggressor 13 victim 12
    cfg(0, 0, 0, 0); wr(12, 0);
    cfg(4, 12, 13, 2);
    wr(13, 1); rd(12, "R7"); wr(13, 0); rd(12, "R7");

    // R8: victim equal to aggressor
    cfg(3, 7, 7, 1);
    wr(7, 0); wr(7, 1); rd(7, "R8");

    // R9: corner victim 0 with neighbours 1 and 4
    cfg(0, 0, 0, 0); wr(0, 0); wr(1, 0); wr(4, 0);
    cfg(5, 0, 0, 0);
    wr(1, 1); rd(0, "R9"); wr(4, 1); rd(0, "R9");

    // R10: centre victim 5, diagonal 10 at 0
    cfg(0, 0, 0, 0);
    for (int i = 0; i < CELLS; i++) wr(i, 1'(i != 5 && i != 10));
    cfg(6, 5, 0, 0);
    wr(15, 1); rd(5, "R10"); wr(10, 1); rd(5, "R10");
    cfg(5, 5, 0, 0);
    wr(5, 0); rd(5, "R9");

    // Random phases with biased addressing
    for (int k = 0; k < 40; k++) begin
      int code = $urandom_range(0, 8);
      int v    = $urandom_range(0, CELLS - 1);
      int ag   = $urandom_range(0, CELLS - 1);
      cfg(code, v, ag, $urandom_range(0, 3));
      for (int n = 0; n < 120; n++) begin
        int sel = $urandom_range(0, 3);
        int a;
        bit d;
        case (sel)
          0: a = mVic;
          1: a = mAgg;
          2: a = (mVic + offs[$urandom_range(0, 7)] + CELLS) % CELLS;
          default: a = $urandom_range(0, CELLS - 1);
        endcase
        d = (mKind >= 5) ? ($urandom_range(0, 3) != 0) : 1'($urandom_range(0, 1));
        if ($urandom_range(0, 1) == 0) wr(a, d);
        else rd(a, "");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule